// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves data between system memory and a storage-card data FIFO. It takes its instructions from a linked list of descriptors held in memory. Each descriptor is four 32-bit words: a flags word, a byte count, a buffer address and a link word. Software lays out the list, writes the address of the head descriptor into the base register, chooses a direction and turns the engine on. The engine fetches each descriptor in turn. It streams the buffer words out to the FIFO (transmit) or fills the buffer from the FIFO (receive). When a buffer is finished, the engine writes the flags word back with the ownership bit cleared.

Completion and fault events collect in a write-one-to-clear status register. A separate enable register masks each status bit onto one interrupt line. A descriptor that the engine does not own stops the walk without any further memory access. A descriptor whose byte count is malformed is marked in memory and stops the walk.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset the status register reads 0, the interrupt line is low, no memory request, stream valid or stream ready is asserted, and busy is low.
- R2: Register addresses are 0 control, 1 interrupt enable, 2 status and 3 list base. Read data appears on reg_rdata one clock after reg_addr is presented. Control bits are: bit 0 enable, bit 1 fixed burst (stored only), bit 2 soft reset, bit 3 receive direction. A walk starts when enable goes from 0 to 1. The walk begins by reading four words at the list base.
- R3: If the fetched flags word has bit 31 (owned) clear, the engine stops and sets status bit 4. It reads none of the other descriptor words and writes nothing to memory.
- R4: When a descriptor finishes, its flags word is written back to the descriptor address with bit 31 cleared. Every other bit is preserved, except as R9 states.
- R5: In transmit mode the buffer words are presented on tx_data in ascending address order, one word per valid/ready handshake.
- R6: In receive mode each word accepted on rx_data is written to the buffer at ascending word addresses.
- R7: The next descriptor address is the link word when flags bit 4 is set, and the current address plus 16 otherwise. After a descriptor with bit 2 (last) set is written back, the engine stops. It then sets status bit 0 in transmit mode or bit 1 in receive mode.
- R8: A descriptor that is not the last and has bit 1 (interrupt suppress) clear also sets the direction's done bit when it is written back, and the walk continues.
- R9: A byte count that is not a multiple of 4, or that exceeds MAX_BYTES, moves no data. The flags word is then written back with bit 30 set and bit 31 cleared, status bit 5 is set, and the walk stops. A count of exactly MAX_BYTES is accepted, and a count of zero moves no data.
- R10: Writing a 1 to a status bit clears it. If an event sets the same bit in the same cycle, the set wins.
- R11: irq is a registered OR, over all bits, of status AND enable.
- R12: Writing control bit 2 returns the engine to idle and clears the status register. One clock later the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, with read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_ready | input | 1 | FIFO accepts transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Engine accepts receive word |
| busy | output | 1 | Engine is walking a list |

## Verification
The bench builds the engine with a 16-bit address and MAX_BYTES of 64. With that limit, both the oversize rejection and the exactly-at-limit buffer fit in runs of a few dozen cycles. The memory model acknowledges with a one-cycle delay, and both stream partners stall on a repeating pattern, so every handshake state of the walker is exercised. A behavioural model predicts the transmit stream word by word and checks each handshake as it happens. It also predicts the memory image and status after each walk.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int FLAG_OWN   = 31;
  localparam int FLAG_ERR   = 30;
  localparam int FLAG_CHAIN = 4;
  localparam int FLAG_FIRST = 3;
  localparam int FLAG_LAST  = 2;
  localparam int FLAG_NOIRQ = 1;

  localparam int ST_W      = 6;
  localparam int ST_TXDONE = 0;
  localparam int ST_RXDONE = 1;
  localparam int ST_UNAV   = 4;
  localparam int ST_DERR   = 5;

  localparam int CTL_EN    = 0;
  localparam int CTL_BURST = 1;
  localparam int CTL_SRST  = 2;
  localparam int CTL_RX    = 3;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_IEN  = 2'd1,
    RA_STAT = 2'd2,
    RA_BASE = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_CHECK, W_DRD, W_TXP, W_RXP, W_DWR, W_WB
  } walk_state_e;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [ST_W-1:0] stat_set,
  output logic            irq,
  output logic            go,
  output logic            rx_mode,
  output logic [AW-1:0]   base,
  output logic            srst
);
  logic [3:0]      ctrl_q;
  logic [ST_W-1:0] ien_q;
  logic [ST_W-1:0] stat_q;
  logic            en_q;
  logic            stat_wr;

  assign stat_wr = reg_we && (reg_addr == RA_STAT);
  assign srst    = rst || ctrl_q[CTL_SRST];
  assign rx_mode = ctrl_q[CTL_RX];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      base   <= '0;
      en_q   <= 1'b0;
      go     <= 1'b0;
    end else if (ctrl_q[CTL_SRST]) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      go     <= 1'b0;
    end else begin
      en_q <= ctrl_q[CTL_EN];
      go   <= ctrl_q[CTL_EN] && !en_q;
      if (reg_we && reg_addr == RA_CTRL) ctrl_q <= reg_wdata[3:0];
      if (reg_we && reg_addr == RA_IEN)  ien_q  <= reg_wdata[ST_W-1:0];
      if (reg_we && reg_addr == RA_BASE) base   <= reg_wdata[AW-1:0];
    end
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (srst)                          stat_q[i] <= 1'b0;
      else if (stat_set[i])              stat_q[i] <= 1'b1;
      else if (stat_wr && reg_wdata[i])  stat_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= |(stat_q & ien_q);
      case (reg_addr)
        RA_CTRL: reg_rdata <= 32'(ctrl_q);
        RA_IEN:  reg_rdata <= 32'(ien_q);
        RA_STAT: reg_rdata <= 32'(stat_q);
        default: reg_rdata <= 32'(base);
      endcase
    end
  end

  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (srst)
    (stat_wr && reg_wdata[0] && !stat_set[0]) |=> !stat_q[0]);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (srst)
    stat_set[ST_DERR] |=> stat_q[ST_DERR]);
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ien_q) == '0) |=> !irq);
  a_r12_srst_selfclear: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_SRST] |=> (ctrl_q == 4'd0));
endmodule

// File: rtl/cdma_walker.sv
module cdma_walker
  import cdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic            clk,
  input  logic            srst,
  input  logic            go,
  input  logic            rx_mode,
  input  logic [AW-1:0]   base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [31:0]     tx_data,
  input  logic            tx_ready,
  input  logic            rx_valid,
  input  logic [31:0]     rx_data,
  output logic            rx_ready,
  output logic [ST_W-1:0] stat_set,
  output logic            busy
);
  localparam int LW = $clog2(MAX_BYTES / 4) + 1;

  walk_state_e   state;
  logic [31:0]   cfg, cnt;
  logic [AW-1:0] cur, bufp, nxt, dptr, next_cur;
  logic [1:0]    widx;
  logic [LW-1:0] left;
  logic          dir, bad, cnt_bad;

  assign cnt_bad  = (cnt[1:0] != 2'b00) || (cnt > 32'(MAX_BYTES));
  assign next_cur = cfg[FLAG_CHAIN] ? nxt : cur + AW'(16);
  assign busy     = (state != W_IDLE);

  always_ff @(posedge clk) begin
    if (srst) begin
      state <= W_IDLE;  mem_req <= 1'b0; mem_we <= 1'b0;
      mem_addr <= '0;   mem_wdata <= '0; tx_valid <= 1'b0;
      tx_data <= '0;    rx_ready <= 1'b0; stat_set <= '0;
      cfg <= '0; cnt <= '0; cur <= '0; bufp <= '0; nxt <= '0;
      dptr <= '0; widx <= '0; left <= '0; dir <= 1'b0; bad <= 1'b0;
    end else begin
      stat_set <= '0;
      case (state)
        W_IDLE: if (go) begin
          cur <= base; dir <= rx_mode; widx <= 2'd0;
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= base;
          state <= W_FETCH;
        end
        W_FETCH: if (mem_ack) begin
          mem_req <= 1'b0;
          case (widx)
            2'd0:    cfg  <= mem_rdata;
            2'd1:    cnt  <= mem_rdata;
            2'd2:    bufp <= mem_rdata[AW-1:0];
            default: nxt  <= mem_rdata[AW-1:0];
          endcase
          if (widx == 2'd0 && !mem_rdata[FLAG_OWN]) begin
            stat_set[ST_UNAV] <= 1'b1;
            state <= W_IDLE;
          end else if (widx == 2'd3) begin
            state <= W_CHECK;
          end else begin
            widx <= widx + 2'd1;
            mem_req <= 1'b1;
            mem_addr <= cur + AW'({widx + 2'd1, 2'b00});
          end
        end
        W_CHECK: begin
          bad <= cnt_bad;
          if (cnt_bad || cnt[31:2] == 30'd0) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur;
            mem_wdata <= {1'b0, cfg[FLAG_ERR] | cnt_bad, cfg[29:0]};
            state <= W_WB;
          end else begin
            dptr <= bufp;
            left <= cnt[LW+1:2];
            if (dir) begin
              rx_ready <= 1'b1;
              state <= W_RXP;
            end else begin
              mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= bufp;
              state <= W_DRD;
            end
          end
        end
        W_DRD: if (mem_ack) begin
          mem_req <= 1'b0; tx_valid <= 1'b1; tx_data <= mem_rdata;
          state <= W_TXP;
        end
        W_TXP: if (tx_ready) begin
          tx_valid <= 1'b0;
          dptr <= dptr + AW'(4);
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur;
            mem_wdata <= {1'b0, cfg[30:0]};
            state <= W_WB;
          end else begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= dptr + AW'(4);
            state <= W_DRD;
          end
        end
        W_RXP: if (rx_valid) begin
          rx_ready <= 1'b0;
          mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= dptr; mem_wdata <= rx_data;
          state <= W_DWR;
        end
        W_DWR: if (mem_ack) begin
          mem_req <= 1'b0; mem_we <= 1'b0;
          dptr <= dptr + AW'(4);
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= cur;
            mem_wdata <= {1'b0, cfg[30:0]};
            state <= W_WB;
          end else begin
            rx_ready <= 1'b1;
            state <= W_RXP;
          end
        end
        W_WB: if (mem_ack) begin
          mem_req <= 1'b0; mem_we <= 1'b0;
          if (bad) begin
            stat_set[ST_DERR] <= 1'b1;
            state <= W_IDLE;
          end else if (cfg[FLAG_LAST]) begin
            stat_set[dir ? ST_RXDONE : ST_TXDONE] <= 1'b1;
            state <= W_IDLE;
          end else begin
            if (!cfg[FLAG_NOIRQ]) stat_set[dir ? ST_RXDONE : ST_TXDONE] <= 1'b1;
            cur <= next_cur; widx <= 2'd0;
            mem_req <= 1'b1; mem_addr <= next_cur;
            state <= W_FETCH;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (srst)
    (state == W_IDLE) |-> (!mem_req && !tx_valid && !rx_ready));
  a_r2_req_held: assert property (@(posedge clk) disable iff (srst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (srst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r4_wb_unowned: assert property (@(posedge clk) disable iff (srst)
    (state == W_WB && mem_req) |-> (mem_we && !mem_wdata[FLAG_OWN]));
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (srst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import cdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  output logic          rx_ready,
  output logic          busy
);
  logic [ST_W-1:0] stat_set;
  logic            go, rx_mode, srst;
  logic [AW-1:0]   base;

  cdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
    .irq(irq), .go(go), .rx_mode(rx_mode), .base(base), .srst(srst)
  );

  cdma_walker #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_walk (
    .clk(clk), .srst(srst), .go(go), .rx_mode(rx_mode), .base(base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .stat_set(stat_set), .busy(busy)
  );
endmodule

// File: tb/test_chain_dma_engine.sv
module test_chain_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MAXB = 64;
  localparam logic [31:0] OWN = 32'h8000_0000, ERR = 32'h4000_0000;
  localparam logic [31:0] CH = 32'h10, FST = 32'h8, LST = 32'h4, DIC = 32'h2;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, busy;
  logic [31:0] tx_data, rx_data = '0;

  int checks = 0, errors = 0, cyc = 0, tx_n = 0, rx_idx = 0, rx_n = 0;
  bit rv_seen = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_tx [$];
  logic [31:0] rx_src [0:15];

  chain_dma_engine #(.AW(AW), .MAX_BYTES(MAXB)) i_chain_dma_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory and stream partners, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else mem_rdata = mem[mem_addr[9:2]];
      mem_ack = 1'b1;
    end else mem_ack = 1'b0;
    tx_ready = (cyc % 3) != 0;
    if (tx_valid && tx_ready) begin
      tx_n++;
      if (exp_tx.size() == 0) chk("R5 unexpected tx word", tx_data, 32'hx);
      else chk("R5 tx word order", tx_data, exp_tx.pop_front());
    end
    if (rv_seen) rx_idx++;
    rx_valid = (rx_idx < rx_n) && ((cyc % 4) != 1);
    rx_data  = rx_src[rx_idx % 16];
    rv_seen  = rx_valid && rx_ready;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] f, c, b, n);
    mem[a/4] = f; mem[a/4+1] = c; mem[a/4+2] = b; mem[a/4+3] = n;
  endtask

  task automatic run(input logic [31:0] base, input bit rx);
    wr_reg(2'd3, base);
    wr_reg(2'd0, 32'd0);
    wr_reg(2'd0, 32'd1 | (32'(rx) << 3));
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i);
    for (int i = 0; i < 16; i++) rx_src[i] = 32'h1111_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 busy/valid/ready", {29'd0, busy, tx_valid, rx_ready}, 32'd0);
    rd_reg(2'd2, d); chk("R1 status", d, 32'd0);
    wr_reg(2'd1, 32'h3F);
    rd_reg(2'd1, d); chk("R2 enable readback", d, 32'h3F);

    // R2 R4 R5 R7: transmit chain, three linked descriptors out of order
    put_desc('h100, OWN|CH|FST|DIC, 8,  'h200, 'h180);
    put_desc('h180, OWN|CH|DIC,     12, 'h300, 'h140);
    put_desc('h140, OWN|CH|LST,     4,  'h280, 0);
    exp_tx = {mem['h80], mem['h81], mem['hC0], mem['hC1], mem['hC2], mem['hA0]};
    tx_n = 0;
    run('h100, 1'b0);
    chk("R5 tx word count", 32'(tx_n), 32'd6);
    chk("R4 flags wb d0", mem['h100/4], CH|FST|DIC);
    chk("R4 flags wb d1", mem['h180/4], CH|DIC);
    chk("R7 flags wb last", mem['h140/4], CH|LST);
    rd_reg(2'd2, d); chk("R7 tx done status", d, 32'h1);
    chk("R11 irq on tx done", {31'd0, irq}, 32'd1);

    // R10 write one to clear
    wr_reg(2'd2, 32'h1);
    rd_reg(2'd2, d); chk("R10 w1c", d, 32'd0);
    @(negedge clk);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);

    // R6 R7 R11: receive, sequential (no link) descriptors
    wr_reg(2'd1, 32'h1);
    put_desc('h040, OWN|FST|DIC, 8, 'h360, 'hFFF0);
    put_desc('h050, OWN|LST,     8, 'h3A0, 0);
    rx_idx = 0; rx_n = 4;
    run('h040, 1'b1);
    chk("R6 rx word0", mem['h360/4],   rx_src[0]);
    chk("R6 rx word1", mem['h360/4+1], rx_src[1]);
    chk("R6 rx word2", mem['h3A0/4],   rx_src[2]);
    chk("R6 rx word3", mem['h3A0/4+1], rx_src[3]);
    chk("R7 rx sequential next wb", mem['h050/4], LST);
    rd_reg(2'd2, d); chk("R7 rx done status", d, 32'h2);
    chk("R11 masked irq", {31'd0, irq}, 32'd0);
    wr_reg(2'd1, 32'h3F);
    rd_reg(2'd1, d);
    chk("R11 unmasked irq", {31'd0, irq}, 32'd1);
    wr_reg(2'd2, 32'h3F);

    // R3 unowned head descriptor
    put_desc('h0C0, FST|LST, 8, 'h200, 0);
    d = mem['h0C0/4 + 1];
    tx_n = 0;
    run('h0C0, 1'b0);
    rd_reg(2'd2, d); chk("R3 unavailable status", d, 32'h10);
    chk("R3 flags untouched", mem['h0C0/4], FST|LST);
    chk("R3 no data moved", 32'(tx_n), 32'd0);
    wr_reg(2'd2, 32'h3F);

    // R9 misaligned count aborts chain
    put_desc('h0D0, OWN|CH|FST|DIC, 6, 'h200, 'h0E0);
    put_desc('h0E0, OWN|LST, 4, 'h200, 0);
    tx_n = 0;
    run('h0D0, 1'b0);
    rd_reg(2'd2, d); chk("R9 error status", d, 32'h20);
    chk("R9 flags error", mem['h0D0/4], ERR|CH|FST|DIC);
    chk("R9 chain aborted", mem['h0E0/4], OWN|LST);
    chk("R9 no data", 32'(tx_n), 32'd0);
    wr_reg(2'd2, 32'h3F);

    // R9 oversize count
    put_desc('h0C0, OWN|FST|LST, MAXB + 4, 'h200, 0);
    run('h0C0, 1'b0);
    rd_reg(2'd2, d); chk("R9 oversize status", d, 32'h20);
    chk("R9 oversize flags", mem['h0C0/4], ERR|FST|LST);
    wr_reg(2'd2, 32'h3F);

    // R9 exactly MAX_BYTES accepted
    put_desc('h020, OWN|FST|LST, MAXB, 'h200, 0);
    for (int i = 0; i < MAXB/4; i++) exp_tx.push_back(mem['h80 + i]);
    tx_n = 0;
    run('h020, 1'b0);
    chk("R9 max-size words", 32'(tx_n), 32'(MAXB/4));
    rd_reg(2'd2, d); chk("R9 max-size done", d, 32'h1);
    wr_reg(2'd2, 32'h3F);

    // R8 per-descriptor completion, zero count, then unowned successor
    put_desc('h060, OWN|CH|FST, 0, 'h200, 'h070);
    put_desc('h070, LST, 4, 'h200, 0);
    tx_n = 0;
    run('h060, 1'b0);
    rd_reg(2'd2, d); chk("R8 done plus unavailable", d, 32'h11);
    chk("R8 zero-count wb", mem['h060/4], CH|FST);
    chk("R9 zero count no data", 32'(tx_n), 32'd0);

    // R12 soft reset
    wr_reg(2'd0, 32'h4);
    rd_reg(2'd0, d); chk("R12 control self-clears", d, 32'd0);
    rd_reg(2'd2, d); chk("R12 status cleared", d, 32'd0);
    chk("R12 idle", {31'd0, busy}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule